// File: doc/BRIEF.md
# L2 Hit Sampling Memory-Start Gate

This block sits between a processor bus and the system memory controller on a bus that an external second-level cache also watches. Each transfer start strobe opens a short decision window. When the cache is enabled and the transfer is cacheable, the block samples the cache's hit input once, after a programmable delay. On a hit the external cache completes the transfer, so the memory access is withheld. On a miss the block releases a memory-start pulse.

The memory-start pulse never comes earlier than three cycles after the strobe. An address retry seen during the window cancels the transfer, and a retry overrides a hit. Transfers to on-chip register space, to local-bus banks, or marked caching-inhibited skip hit sampling. Only one transfer is tracked at a time. A strobe that arrives while the block is busy raises an error pulse and is otherwise ignored.

Top module: `l2_hit_gate`

## Requirements
- R1: While `rst_ni` is low, `mem_start_o`, `l2_served_o`, `retried_o` and `proto_err_o` are all 0, and no transfer is pending.
- R2: When `l2_en_i` is 0 at the strobe, `hit_i` has no effect, and the transfer gets `mem_start_o` in cycle c+3, where cycle c is the one in which `ts_i` was high.
- R3: For an eligible transfer, `hit_i` is sampled only in cycle c+`l2_dly_i`+1. Its value in any other cycle has no effect.
- R4: An eligible transfer that is sampled as a hit and is not retried gives one `l2_served_o` pulse in cycle c+max(3, `l2_dly_i`+2), and gives no `mem_start_o`.
- R5: An eligible transfer that is sampled as a miss and is not retried gives one `mem_start_o` pulse in cycle c+max(3, `l2_dly_i`+2), and never before c+3.
- R6: A transfer with `nc_space_i`=1 (on-chip register space or local-bus bank) is not eligible. It gets `mem_start_o` in cycle c+3 whatever `hit_i` does.
- R7: A transfer with `ci_i`=1 (caching-inhibited) is not eligible. It gets `mem_start_o` in cycle c+3 whatever `hit_i` does.
- R8: A `retry_i` high in any cycle from c+1 up to the cycle before the outcome cycle gives `retried_o` in the outcome cycle in place of either other pulse, even when a hit was sampled.
- R9: Each accepted strobe gives exactly one single-cycle pulse on exactly one of `mem_start_o`, `l2_served_o` and `retried_o`, and the outcome cycle is no later than c+5.
- R10: A `ts_i` high while a transfer is pending (cycles c+1 up to the cycle before the outcome) gives `proto_err_o` high in the next cycle and does not change the pending transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| l2_en_i | input | 1 | External cache present and enabled |
| l2_dly_i | input | 2 | Hit sampling delay; hit is sampled delay+1 cycles after the strobe |
| ts_i | input | 1 | Transfer start strobe |
| ci_i | input | 1 | Transfer is caching-inhibited |
| nc_space_i | input | 1 | Transfer targets on-chip register space or a local-bus bank |
| hit_i | input | 1 | External cache hit indication |
| retry_i | input | 1 | Address retry for the pending transfer |
| mem_start_o | output | 1 | One-cycle pulse that starts the system memory access |
| l2_served_o | output | 1 | One-cycle pulse: the external cache serves the transfer |
| retried_o | output | 1 | One-cycle pulse: the transfer was cancelled by retry |
| proto_err_o | output | 1 | One-cycle pulse: a strobe arrived while busy and was dropped |

## Verification
The bench holds `hit_i` high in the cycles around the sample point but low at the sample point itself. A design that samples at the wrong cycle would then report a hit. It runs each delay setting with hit and miss, because a design that ignores the three-cycle floor would fire memory in cycle c+2 when the delay is 0. Retry is raised together with a sampled hit, and also in the last cycle before the outcome; a design that lets a hit win, or that closes the retry window early, gives the wrong pulse. Strobes are injected while busy, to catch a design that restarts its timer or loses the error pulse. Cacheable, caching-inhibited, no-cache-space and cache-disabled transfers are mixed, so a design that lets hits through for ineligible transfers is caught.

// File: rtl/l2g_pkg.sv
package l2g_pkg;
  localparam int DLY_W     = 2;
  localparam int MIN_START = 3;  // earliest outcome cycle after strobe
  localparam int MAX_FIN   = (MIN_START - 1 > (1 << DLY_W)) ? MIN_START - 1 : (1 << DLY_W);
  localparam int CNT_W     = $clog2(MAX_FIN + 1);
  localparam int MAX_OUT   = MAX_FIN + 1;

  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_MEM   = 2'd1,
    OUT_L2    = 2'd2,
    OUT_RETRY = 2'd3
  } outcome_e;
endpackage

// File: rtl/l2g_timer.sv
module l2g_timer
  import l2g_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] fin_i,
  input  logic [CNT_W-1:0] smp_i,
  output logic             busy_o,
  output logic             at_smp_o,
  output logic             at_fin_o
);
  logic [CNT_W-1:0] cnt_q, fin_q, smp_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      fin_q  <= '0;
      smp_q  <= '0;
    end else if (accept_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(1);
      fin_q  <= fin_i;
      smp_q  <= smp_i;
    end else if (busy_q) begin
      if (cnt_q == fin_q) busy_q <= 1'b0;
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign busy_o   = busy_q;
  assign at_smp_o = busy_q && (cnt_q == smp_q);
  assign at_fin_o = busy_q && (cnt_q == fin_q);
endmodule

// File: rtl/l2g_decide.sv
module l2g_decide
  import l2g_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic elig_i,
  input  logic busy_i,
  input  logic at_smp_i,
  input  logic at_fin_i,
  input  logic hit_i,
  input  logic retry_i,
  output logic mem_start_o,
  output logic l2_served_o,
  output logic retried_o
);
  logic     elig_q, hit_q, ret_q;
  logic     hit_now, ret_now;
  outcome_e res_d, res_q;

  assign hit_now = hit_q || (at_smp_i && elig_q && hit_i);
  assign ret_now = ret_q || retry_i;

  always_comb begin
    res_d = OUT_NONE;
    if (at_fin_i) begin
      if (ret_now)      res_d = OUT_RETRY;  // retry beats hit
      else if (hit_now) res_d = OUT_L2;
      else              res_d = OUT_MEM;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elig_q <= 1'b0;
      hit_q  <= 1'b0;
      ret_q  <= 1'b0;
      res_q  <= OUT_NONE;
    end else begin
      res_q <= res_d;
      if (accept_i) begin
        elig_q <= elig_i;
        hit_q  <= 1'b0;
        ret_q  <= 1'b0;
      end else if (busy_i) begin
        if (retry_i) ret_q <= 1'b1;
        if (at_smp_i && elig_q && hit_i) hit_q <= 1'b1;
      end
    end
  end

  assign mem_start_o = (res_q == OUT_MEM);
  assign l2_served_o = (res_q == OUT_L2);
  assign retried_o   = (res_q == OUT_RETRY);
endmodule

// File: rtl/l2_hit_gate.sv
module l2_hit_gate
  import l2g_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             l2_en_i,
  input  logic [DLY_W-1:0] l2_dly_i,
  input  logic             ts_i,
  input  logic             ci_i,
  input  logic             nc_space_i,
  input  logic             hit_i,
  input  logic             retry_i,
  output logic             mem_start_o,
  output logic             l2_served_o,
  output logic             retried_o,
  output logic             proto_err_o
);
  logic             busy, at_smp, at_fin, accept, elig;
  logic [CNT_W-1:0] fin, smp;
  logic             err_q;

  assign accept = ts_i && !busy;
  assign elig   = l2_en_i && !ci_i && !nc_space_i;

  always_comb begin
    int s;
    s   = int'(l2_dly_i) + 1;
    smp = CNT_W'(s);
    if (elig && s > MIN_START - 1) fin = CNT_W'(s);
    else                           fin = CNT_W'(MIN_START - 1);
  end

  l2g_timer u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .fin_i    (fin),
    .smp_i    (smp),
    .busy_o   (busy),
    .at_smp_o (at_smp),
    .at_fin_o (at_fin)
  );

  l2g_decide u_decide (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .elig_i      (elig),
    .busy_i      (busy),
    .at_smp_i    (at_smp),
    .at_fin_i    (at_fin),
    .hit_i       (hit_i),
    .retry_i     (retry_i),
    .mem_start_o (mem_start_o),
    .l2_served_o (l2_served_o),
    .retried_o   (retried_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= ts_i && busy;
  end

  assign proto_err_o = err_q;
endmodule

// File: rtl/l2g_gate_chk.sv
module l2g_gate_chk
  import l2g_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             l2_en_i,
  input logic [DLY_W-1:0] l2_dly_i,
  input logic             ts_i,
  input logic             ci_i,
  input logic             nc_space_i,
  input logic             mem_start_o,
  input logic             l2_served_o,
  input logic             retried_o,
  input logic             proto_err_o
);
  logic       pend, elig_q, outcome, acc;
  logic [3:0] age;

  assign outcome = mem_start_o || l2_served_o || retried_o;
  assign acc     = ts_i && (!pend || outcome);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend   <= 1'b0;
      age    <= '0;
      elig_q <= 1'b0;
    end else if (acc) begin
      pend   <= 1'b1;
      age    <= 4'd1;
      elig_q <= l2_en_i && !ci_i && !nc_space_i;
    end else if (outcome) begin
      pend <= 1'b0;
    end else if (pend && age != 4'hF) begin
      age <= age + 4'd1;
    end
  end

  assert_one_outcome_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_start_o, l2_served_o, retried_o}));

  assert_outcome_needs_txn_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outcome |-> pend);

  assert_min_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outcome |-> (age >= 4'(MIN_START)));

  assert_bounded_wait_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |-> (age <= 4'(MAX_OUT)));

  assert_no_hit_ineligible_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_served_o |-> elig_q);

  assert_err_follows_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> $past(ts_i));

  always_comb begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!mem_start_o && !l2_served_o && !retried_o && !proto_err_o);
  end
endmodule

bind l2_hit_gate l2g_gate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .l2_en_i     (l2_en_i),
  .l2_dly_i    (l2_dly_i),
  .ts_i        (ts_i),
  .ci_i        (ci_i),
  .nc_space_i  (nc_space_i),
  .mem_start_o (mem_start_o),
  .l2_served_o (l2_served_o),
  .retried_o   (retried_o),
  .proto_err_o (proto_err_o)
);

// File: tb/tb_l2_hit_gate.sv
module tb_l2_hit_gate;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       l2_en_i = 1'b0;
  logic [1:0] l2_dly_i = 2'd0;
  logic       ts_i = 1'b0, ci_i = 1'b0, nc_space_i = 1'b0, hit_i = 1'b0, retry_i = 1'b0;
  logic       mem_start_o, l2_served_o, retried_o, proto_err_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  l2_hit_gate dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .l2_en_i(l2_en_i), .l2_dly_i(l2_dly_i),
    .ts_i(ts_i), .ci_i(ci_i), .nc_space_i(nc_space_i), .hit_i(hit_i),
    .retry_i(retry_i), .mem_start_o(mem_start_o), .l2_served_o(l2_served_o),
    .retried_o(retried_o), .proto_err_o(proto_err_o)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic int exp_lat(input bit en, input bit [1:0] dly, input bit ci, input bit nc);
    if (en && !ci && !nc && int'(dly) + 2 > 3) return int'(dly) + 2;
    return 3;
  endfunction

  // 1 mem, 2 served, 3 retried
  function automatic int exp_res(input bit en, input bit [1:0] dly, input bit ci, input bit nc,
                                 input bit [6:0] hitv, input int rc);
    int d;
    d = exp_lat(en, dly, ci, nc);
    if (rc >= 1 && rc <= d - 1) return 3;
    if (en && !ci && !nc && hitv[int'(dly) + 1]) return 2;
    return 1;
  endfunction

  task automatic run_txn(input string tag_in, input bit en, input bit [1:0] dly, input bit ci,
                         input bit nc, input bit [6:0] hitv, input int rc, input int errk);
    int d, r;
    string tag;
    d = exp_lat(en, dly, ci, nc);
    r = exp_res(en, dly, ci, nc, hitv, rc);
    if (tag_in != "")  tag = tag_in;
    else if (r == 3)   tag = "R8";
    else if (!en)      tag = "R2";
    else if (ci)       tag = "R7";
    else if (nc)       tag = "R6";
    else if (r == 2)   tag = "R4";
    else               tag = "R5";
    @(negedge clk_i);
    ts_i = 1'b1; l2_en_i = en; l2_dly_i = dly; ci_i = ci; nc_space_i = nc;
    hit_i = 1'b0; retry_i = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk_i);
      chk(tag, $sformatf("mem_start k=%0d", k), mem_start_o, (k == d && r == 1));
      chk(tag, $sformatf("l2_served k=%0d", k), l2_served_o, (k == d && r == 2));
      chk(tag, $sformatf("retried k=%0d", k), retried_o, (k == d && r == 3));
      chk((errk != 0) ? "R10" : "R9", $sformatf("proto_err k=%0d", k), proto_err_o,
          (errk != 0 && k == errk + 1));
      ts_i    = (errk != 0 && k == errk);
      hit_i   = hitv[k];
      retry_i = (k == rc);
      ci_i = 1'b0; nc_space_i = 1'b0;
    end
    ts_i = 1'b0; hit_i = 1'b0; retry_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset quiet
    repeat (3) @(negedge clk_i);
    ts_i = 1'b1; hit_i = 1'b1;
    @(negedge clk_i);
    chk("R1", "mem_start in reset", mem_start_o, 1'b0);
    chk("R1", "l2_served in reset", l2_served_o, 1'b0);
    chk("R1", "retried in reset", retried_o, 1'b0);
    chk("R1", "proto_err in reset", proto_err_o, 1'b0);
    ts_i = 1'b0; hit_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "no pending after reset", mem_start_o | l2_served_o | retried_o, 1'b0);

    // directed: hit and miss for each delay (R4, R5)
    for (int dl = 0; dl < 4; dl++) begin
      run_txn("R4", 1, 2'(dl), 0, 0, 7'(1 << (dl + 1)), 0, 0);
      run_txn("R5", 1, 2'(dl), 0, 0, 7'h00, 0, 0);
    end
    // R3: hit around the sample point only -> miss
    run_txn("R3", 1, 2'd2, 0, 0, 7'b1110110, 0, 0);
    run_txn("R3", 1, 2'd0, 0, 0, 7'b1111100, 0, 0);
    // R2: cache disabled, hit ignored
    run_txn("R2", 0, 2'd3, 0, 0, 7'h7F, 0, 0);
    // R6, R7: ineligible, hit ignored
    run_txn("R6", 1, 2'd1, 0, 1, 7'h7F, 0, 0);
    run_txn("R7", 1, 2'd3, 1, 0, 7'h7F, 0, 0);
    // R8: retry with hit, and at last window cycle
    run_txn("R8", 1, 2'd1, 0, 0, 7'h7F, 2, 0);
    run_txn("R8", 1, 2'd3, 0, 0, 7'h7F, 4, 0);
    run_txn("R8", 0, 2'd0, 0, 0, 7'h00, 1, 0);
    // R10: strobe while busy, including the last busy cycle
    run_txn("R10", 1, 2'd3, 0, 0, 7'b0010000, 0, 2);
    run_txn("R10", 1, 2'd0, 0, 0, 7'h00, 0, 2);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      bit en, ci, nc;
      bit [1:0] dl;
      bit [6:0] hv;
      int d, rc, ek;
      en = ($urandom_range(0, 3) != 0);
      dl = 2'($urandom_range(0, 3));
      ci = ($urandom_range(0, 5) == 0);
      nc = ($urandom_range(0, 5) == 0);
      hv = 7'($urandom_range(0, 127));
      d  = exp_lat(en, dl, ci, nc);
      rc = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, d - 1)) : 0;
      ek = ($urandom_range(0, 4) == 0) ? int'($urandom_range(1, d - 1)) : 0;
      run_txn("", en, dl, ci, nc, hv, rc, ek);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule